// File: doc/BRIEF.md
# Fractional Clock Pulse Skipper (N/32)

This block turns a free-running parent clock into a clock-enable stream that keeps `mult` out of every 32 parent cycles, for any `mult` from 1 to 32. Cycles are dropped whole and never stretched, so each kept pulse is exactly one parent cycle wide. A downstream gating cell uses the enable to make a slower clock that keeps the parent pulse width but has a different duty cycle. Kept cycles are spread across each 32-cycle frame by a phase accumulator, so the gaps between them differ by at most one cycle.

Software drives the block through a small single-port register interface. A control register at word address 0 holds a 5-bit ratio field at bits 12:8. The field stores `32 - mult`, so 0 means full rate and 31 means one cycle in 32. A second register at word address 1 holds an update request at bit 31. Writing the field alone changes nothing at the output. The new ratio is committed only after the request bit is set. The block applies it at the next 32-cycle frame boundary and clears the request bit one cycle later. Software polls the bit to learn when the change is done, and treats a set bit as busy.

Top module: `pulse_skip_gen`

## Requirements
- R1: Once a ratio is active, every run of 32 consecutive cycles of `clk_keep` contains exactly `32 - field` high cycles.
- R2: The ratio field is bits 12:8 of the control register (address 0). A field of 0 keeps every cycle, and a field of 31 keeps one cycle per frame.
- R3: Writing a word with bit 31 set to the update register (address 1) sets the request bit. It then reads as 1 until the new ratio has been applied. Bits 30:0 of that register read as 0.
- R4: After being set, the request bit clears by itself within 64 cycles, and from then on the output runs at the new ratio.
- R5: Writing a new field without setting the request bit leaves the output rate unchanged.
- R6: While the request bit is set, writes to the control register leave the ratio field unchanged.
- R7: All control register bits outside 12:8 read back as last written, whether or not the request bit is set.
- R8: After reset the control register reads 0, the request bit reads 0, and `clk_keep` is high on every cycle.
- R9: When at most 16 cycles per frame are kept (field 16 or more), `clk_keep` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Word address: 0 control, 1 update request |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| clk_keep | output | 1 | Registered keep enable, one bit per parent cycle |

## Verification
The checker takes for granted that software writes the request bit only through the update register and never writes bit 31 there while it is still set. The bench keeps to this by polling the request bit until it reads 0 before it programs the next ratio. The checker also assumes that reset is held for at least one clock edge. The bench holds it for several edges, and only then does it release reset and start sweeping all 32 field values.

// File: rtl/pulse_skip_pkg.sv
// Package: shared constants for the N/32 pulse skipper.
// Assumes word-addressed registers on a single-port interface.
package pulse_skip_pkg;
    localparam int unsigned PS_DATA_W     = 32;
    localparam int unsigned PS_ADDR_W     = 2;
    localparam int unsigned PS_FRAME_LOG2 = 5;
    localparam int unsigned PS_FIELD_LSB  = 8;
    localparam int unsigned PS_REQ_BIT    = 31;
    localparam logic [PS_ADDR_W-1:0] PS_ADDR_CTRL = 2'd0;
    localparam logic [PS_ADDR_W-1:0] PS_ADDR_REQ  = 2'd1;
endpackage

// File: rtl/pulse_skip_regs.sv
// Register file for the pulse skipper: control word with ratio field and
// self-clearing update request. Assumes `applied` is a one-cycle pulse
// from the frame engine issued only while the request is pending.
module pulse_skip_regs
    import pulse_skip_pkg::*;
#(
    parameter int unsigned DATA_W     = PS_DATA_W,
    parameter int unsigned ADDR_W     = PS_ADDR_W,
    parameter int unsigned FIELD_W    = PS_FRAME_LOG2,
    parameter int unsigned FIELD_LSB  = PS_FIELD_LSB,
    parameter int unsigned REQ_BIT    = PS_REQ_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              applied,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [FIELD_W-1:0] ratio_field,
    output logic              req_q
);
    localparam int unsigned FIELD_MSB = FIELD_LSB + FIELD_W - 1;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ctrl_wr;

    // Merge a write: the ratio field is frozen while a request is pending.
    always_comb begin
        ctrl_wr = reg_wdata;
        if (req_q) begin
            ctrl_wr[FIELD_MSB:FIELD_LSB] = ctrl_q[FIELD_MSB:FIELD_LSB];
        end
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_we && reg_addr == ADDR_W'(PS_ADDR_CTRL)) begin
            ctrl_q <= ctrl_wr;
        end
    end

    // Update request: set by software, cleared by the frame engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (applied) begin
            req_q <= 1'b0;
        end else if (reg_we && reg_addr == ADDR_W'(PS_ADDR_REQ) && reg_wdata[REQ_BIT]) begin
            req_q <= 1'b1;
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(PS_ADDR_CTRL)) begin
            reg_rdata = ctrl_q;
        end else if (reg_addr == ADDR_W'(PS_ADDR_REQ)) begin
            reg_rdata[REQ_BIT] = req_q;
        end
    end

    assign ratio_field = ctrl_q[FIELD_MSB:FIELD_LSB];
endmodule

// File: rtl/pulse_skip_engine.sv
// Frame engine: phase accumulator that keeps `mult` of every 2**FRAME_LOG2
// cycles, plus a frame counter that commits a pending ratio at the frame
// boundary. Assumes the ratio field is stable while `req` is high.
module pulse_skip_engine
    import pulse_skip_pkg::*;
#(
    parameter int unsigned FRAME_LOG2 = PS_FRAME_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [FRAME_LOG2-1:0] ratio_field,
    output logic                  applied,
    output logic [FRAME_LOG2:0]   active_mult,
    output logic [FRAME_LOG2-1:0] frame_pos,
    output logic                  clk_keep
);
    localparam int unsigned MULT_W = FRAME_LOG2 + 1;
    localparam logic [MULT_W-1:0] FRAME = MULT_W'(1) << FRAME_LOG2;
    localparam logic [FRAME_LOG2-1:0] LAST_POS = '1;

    logic [FRAME_LOG2-1:0] phase_q;
    logic [MULT_W-1:0]     phase_sum;
    logic [MULT_W-1:0]     next_mult;
    logic                  at_boundary;

    assign phase_sum   = {1'b0, phase_q} + active_mult;
    assign next_mult   = FRAME - {1'b0, ratio_field};
    assign at_boundary = (frame_pos == LAST_POS);

    // Frame position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_pos <= '0;
        else        frame_pos <= frame_pos + 1'b1;
    end

    // Phase accumulator and registered keep enable (carry out = keep).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            clk_keep <= 1'b1;
        end else begin
            phase_q  <= phase_sum[FRAME_LOG2-1:0];
            clk_keep <= phase_sum[FRAME_LOG2];
        end
    end

    // Commit a pending ratio at the end of a frame; flag it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_mult <= FRAME;
            applied     <= 1'b0;
        end else begin
            applied <= 1'b0;
            if (req && at_boundary && !applied) begin
                active_mult <= next_mult;
                applied     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_skip_gen.sv
// Top of the N/32 pulse skipper: register file plus frame engine.
// Assumes a single parent clock domain and synchronous active-low reset.
module pulse_skip_gen
    import pulse_skip_pkg::*;
#(
    parameter int unsigned DATA_W     = PS_DATA_W,
    parameter int unsigned ADDR_W     = PS_ADDR_W,
    parameter int unsigned FRAME_LOG2 = PS_FRAME_LOG2,
    parameter int unsigned FIELD_LSB  = PS_FIELD_LSB,
    parameter int unsigned REQ_BIT    = PS_REQ_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_keep
);
    logic [FRAME_LOG2-1:0] ratio_field;
    logic                  req_q;
    logic                  applied;
    logic [FRAME_LOG2:0]   active_mult;
    logic [FRAME_LOG2-1:0] frame_pos;

    pulse_skip_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FRAME_LOG2),
        .FIELD_LSB(FIELD_LSB), .REQ_BIT(REQ_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .applied(applied), .reg_rdata(reg_rdata),
        .ratio_field(ratio_field), .req_q(req_q)
    );

    pulse_skip_engine #(
        .FRAME_LOG2(FRAME_LOG2)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .req(req_q), .ratio_field(ratio_field),
        .applied(applied), .active_mult(active_mult), .frame_pos(frame_pos),
        .clk_keep(clk_keep)
    );
endmodule

// File: rtl/pulse_skip_chk.sv
// Checker for pulse_skip_gen, attached by bind. Assumes the update request
// is never re-written while it is pending.
module pulse_skip_chk #(
    parameter int unsigned FRAME_LOG2 = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_q,
    input logic                  applied,
    input logic [FRAME_LOG2-1:0] ratio_field,
    input logic [FRAME_LOG2:0]   active_mult,
    input logic [FRAME_LOG2-1:0] frame_pos,
    input logic                  clk_keep
);
    localparam int unsigned LIMIT = 2 << FRAME_LOG2;
    localparam int unsigned CNT_W = $clog2(LIMIT) + 1;
    localparam logic [FRAME_LOG2:0] HALF = (FRAME_LOG2 + 1)'(1) << (FRAME_LOG2 - 1);
    localparam logic [FRAME_LOG2:0] FULL = (FRAME_LOG2 + 1)'(1) << FRAME_LOG2;

    logic [CNT_W-1:0] pend_cnt;

    // Count consecutive cycles with the request pending.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_cnt <= '0;
        else if (req_q) pend_cnt <= pend_cnt + 1'b1;
        else            pend_cnt <= '0;
    end

    a_r4_req_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt < CNT_W'(LIMIT));

    a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !applied) |=> req_q);

    a_r6_field_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> $stable(ratio_field));

    a_r5_mult_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_q && frame_pos == '1) |=> $stable(active_mult));

    a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mult == FULL) |=> clk_keep);

    a_r9_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_keep && active_mult <= HALF) |=> !clk_keep);
endmodule

bind pulse_skip_gen pulse_skip_chk #(.FRAME_LOG2(FRAME_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_q(req_q), .applied(applied),
    .ratio_field(ratio_field), .active_mult(active_mult),
    .frame_pos(frame_pos), .clk_keep(clk_keep)
);

// File: tb/test_pulse_skip_gen.sv
// Bench: sweeps all 32 ratio fields, checks rate, handshake and field rules.
module test_pulse_skip_gen;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_keep;

    int n_checks = 0;
    int n_fail = 0;

    pulse_skip_gen i_pulse_skip_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_keep(clk_keep)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic window(output int cnt, output bit adj);
        bit prev = 1'b0;
        cnt = 0; adj = 1'b0;
        for (int i = 0; i < FRAME; i++) begin
            if (clk_keep) begin
                cnt++;
                if (prev) adj = 1'b1;
            end
            prev = clk_keep;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ctrl_exp;
        int cnt;
        bit adj;
        int prev_mult;
        int waited;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        rd(2'd0, d); check(d == 0, "R8 ctrl", d, 0);
        rd(2'd1, d); check(d == 0, "R8 req", d, 0);
        window(cnt, adj); check(cnt == FRAME, "R8 full rate", cnt, FRAME);
        prev_mult = FRAME;

        for (int f = 0; f < FRAME; f++) begin
            ctrl_exp = ((32'h0101_0101 * (f + 1)) ^ 32'hA5C3_0000) & ~32'h0000_1F00;
            ctrl_exp = ctrl_exp | (32'(f) << 8);
            wr(2'd0, ctrl_exp);
            // R2 / R7: field position and readback
            rd(2'd0, d); check(d == ctrl_exp, "R7 readback", d, ctrl_exp);
            check(d[12:8] == f[4:0], "R2 field", d[12:8], f);
            // R5: no request, no change
            window(cnt, adj); check(cnt == prev_mult, "R5 rate held", cnt, prev_mult);

            wr(2'd1, 32'h8000_0000);
            rd(2'd1, d); check(d == 32'h8000_0000, "R3 req set", d, 32'h8000_0000);
            waited = 2;

            if (f % 4 == 1) begin
                // R6: field frozen, other bits still written (R7)
                logic [31:0] alt;
                alt = ~ctrl_exp ^ (32'(f ^ 5) << 8);
                wr(2'd0, alt);
                ctrl_exp = (alt & ~32'h0000_1F00) | (32'(f) << 8);
                rd(2'd0, d);
                check(d[12:8] == f[4:0], "R6 field ignored", d[12:8], f);
                check(d == ctrl_exp, "R7 other bits", d, ctrl_exp);
                waited += 2;
            end

            // R4: poll for completion
            d = 32'h8000_0000;
            while (d[31] && waited < 100) begin
                rd(2'd1, d);
                waited++;
            end
            check(d[31] == 1'b0 && waited <= 64, "R4 req cleared", waited, 64);

            repeat (FRAME) @(negedge clk);
            window(cnt, adj);
            check(cnt == FRAME - f, "R1 kept per window", cnt, FRAME - f);
            if (f >= 16) check(!adj, "R9 no adjacent", adj, 0);
            prev_mult = FRAME - f;
        end

        // R2: full rate restored with field 0
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h8000_0000);
        repeat (80) @(negedge clk);
        window(cnt, adj); check(cnt == FRAME, "R2 full rate", cnt, FRAME);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule